// File: doc/BRIEF.md
# Converter Power and Conversion Sequencer

This block is the digital control core of a serial-output data converter that powers itself down automatically. It watches a conversion-start pin, a read-activity input and a serial clock, all asynchronous to the system clock. It steps through four phases: off, powering up, tracking and converting. The durations of powering up and converting are parameters counted in system-clock cycles. The analog path is not modelled. A stand-in input supplies the value that the conversion captures at the instant of hold.

The level of the start pin at the last cycle of a conversion selects the operating style. If the pin is high, the block stays powered and goes back to tracking, which suits back-to-back sampling. If the pin is low, the block drops to the off phase, which saves power at low sample rates. Results go into an output shift register and are read most significant bit first. When a read is still in progress as a conversion finishes, the new result waits in a side register and is loaded only after the read ends.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the block is off: `powered`, `ready`, `busy`, `dout_en`, `dout` and `pend_ignored` are all 0.
- R2: A rising edge on `conv_start` while off starts power-up. `powered` goes to 1 and `ready` stays 0 for PU_CYC cycles, then `ready` becomes 1.
- R3: A falling edge on `conv_start` while `ready` is 1 starts a conversion. `sample_in` is captured at that moment, and `busy` is 1 for CV_CYC cycles.
- R4: If `conv_start` is high in the last conversion cycle, the block returns to tracking (`ready` = 1) and stays powered.
- R5: If `conv_start` is low in the last conversion cycle, the block powers down (`powered` = 0).
- R6: A falling edge on `conv_start` during power-up starts no conversion and sets `pend_ignored` to 1. The flag is cleared by the next accepted conversion start.
- R7: A rising edge on `conv_start` enables the serial port, and a falling edge that starts a conversion disables it. `dout_en` = port enabled AND `rd_active`. While `dout_en` is 0, `dout` is 0.
- R8: A read begins when `rd_active` rises, presenting bit RES_W-1 (the MSB) on `dout`. Each falling edge of `sclk` advances to the next lower bit, giving RES_W bits per read.
- R9: A read made before a conversion ends returns the previous result.
- R10: If `rd_active` is high when a conversion ends, the shift register keeps the old result until `rd_active` falls, and the new result is loaded then.
- R11: At most one of `ready` and `busy` is 1, and neither is 1 while `powered` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for all timing |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Asynchronous conversion-start / power pin |
| rd_active | input | 1 | Asynchronous read-in-progress indication |
| sclk | input | 1 | Asynchronous serial clock; bit advances on its falling edge |
| sample_in | input | RES_W | Stand-in conversion value, captured at hold |
| dout | output | 1 | Serial data, MSB first |
| dout_en | output | 1 | Serial output is being driven |
| powered | output | 1 | Block is not in the off phase |
| ready | output | 1 | Tracking and able to accept a conversion start |
| busy | output | 1 | Conversion in progress |
| pend_ignored | output | 1 | A start edge arrived during power-up and was dropped |

## Verification
The conversion cycle is run with the start pin held high and then held low at the end of conversion. The two runs separate the stay-powered path from the power-down path. Reads are made at three points: after a conversion ends, while the block is re-powering, and starting before a conversion ends and lasting past its end. The first two show that the fresh result was latched. The third shows that the old word is kept intact and the new word is loaded only after the read. A start edge during power-up, and a read while the port is disabled, show that these stimuli are ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,
        PH_PWRUP = 2'd1,
        PH_TRACK = 2'd2,
        PH_CONV  = 2'd3
    } phase_e;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        typedef struct packed {
            logic m;
            logic s;
            logic p;
        } sync_t;
        sync_t sy_d, sy_q;

        always_comb begin
            sy_d   = sy_q;
            sy_d.m = async_in[g];
            sy_d.s = sy_q.m;
            sy_d.p = sy_q.s;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sy_q <= '0;
            else        sy_q <= sy_d;
        end

        assign lvl[g]  = sy_q.s;
        assign rise[g] = sy_q.s & ~sy_q.p;
        assign fall[g] = ~sy_q.s & sy_q.p;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int PU_CYC = 188,
    parameter int CV_CYC = 288
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_lvl,
    input  logic             st_rise,
    input  logic             st_fall,
    input  logic [RES_W-1:0] sample_in,
    output phase_e           phase,
    output logic             conv_done,
    output logic [RES_W-1:0] conv_data,
    output logic             pend_ign,
    output logic             port_en
);
    localparam int MAXC  = (PU_CYC > CV_CYC) ? PU_CYC : CV_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] PU_LAST = CNT_W'(PU_CYC - 1);
    localparam logic [CNT_W-1:0] CV_LAST = CNT_W'(CV_CYC - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [RES_W-1:0] data;
        logic             pend;
        logic             port;
        logic             done;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        if (st_rise) c_d.port = 1'b1;
        unique case (c_q.ph)
            PH_OFF: begin
                if (st_rise) begin
                    c_d.ph  = PH_PWRUP;
                    c_d.cnt = '0;
                end
            end
            PH_PWRUP: begin
                if (st_fall) c_d.pend = 1'b1;
                if (c_q.cnt == PU_LAST) begin
                    c_d.ph  = PH_TRACK;
                    c_d.cnt = '0;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            PH_TRACK: begin
                if (st_fall) begin
                    c_d.ph   = PH_CONV;
                    c_d.cnt  = '0;
                    c_d.data = sample_in;
                    c_d.pend = 1'b0;
                    c_d.port = 1'b0;
                end
            end
            PH_CONV: begin
                if (c_q.cnt == CV_LAST) begin
                    c_d.done = 1'b1;
                    c_d.cnt  = '0;
                    c_d.ph   = st_lvl ? PH_TRACK : PH_OFF;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            default: c_d.ph = PH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.ph <= PH_OFF;
        end else begin
            c_q <= c_d;
        end
    end

    assign phase     = c_q.ph;
    assign conv_done = c_q.done;
    assign conv_data = c_q.data;
    assign pend_ign  = c_q.pend;
    assign port_en   = c_q.port;
endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             rd_lvl,
    input  logic             rd_rise,
    input  logic             rd_fall,
    input  logic             port_en,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             dout,
    output logic             dout_en
);
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(RES_W - 1);

    typedef struct packed {
        logic             sck_m;
        logic             sck_s;
        logic             sck_p;
        logic [RES_W-1:0] sr;
        logic [RES_W-1:0] hold;
        logic             pend;
        logic [IDX_W-1:0] idx;
    } shf_t;

    shf_t s_d, s_q;
    logic sck_fall;

    assign sck_fall = ~s_q.sck_s & s_q.sck_p;

    always_comb begin
        s_d       = s_q;
        s_d.sck_m = sclk;
        s_d.sck_s = s_q.sck_m;
        s_d.sck_p = s_q.sck_s;
        if (rd_rise) begin
            s_d.idx = '0;
        end else if (rd_lvl && sck_fall && (s_q.idx != IDX_LAST)) begin
            s_d.idx = s_q.idx + 1'b1;
        end
        if (conv_done) begin
            if (rd_lvl) begin
                s_d.hold = conv_data;
                s_d.pend = 1'b1;
            end else begin
                s_d.sr   = conv_data;
                s_d.pend = 1'b0;
            end
        end else if (rd_fall && s_q.pend) begin
            s_d.sr   = s_q.hold;
            s_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout_en = port_en & rd_lvl;
    assign dout    = dout_en & s_q.sr[IDX_LAST - s_q.idx];
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int PU_CYC = 188,
    parameter int CV_CYC = 288
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic             rd_active,
    input  logic             sclk,
    input  logic [RES_W-1:0] sample_in,
    output logic             dout,
    output logic             dout_en,
    output logic             powered,
    output logic             ready,
    output logic             busy,
    output logic             pend_ignored
);
    localparam int SYNC_N = 2;
    localparam int B_ST   = 0;
    localparam int B_RD   = 1;

    logic [SYNC_N-1:0] s_lvl, s_rise, s_fall;
    phase_e            phase;
    logic              conv_done;
    logic [RES_W-1:0]  conv_data;
    logic              port_en;

    adc_seq_sync #(.N(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({rd_active, conv_start}),
        .lvl      (s_lvl),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    adc_seq_ctrl #(.RES_W(RES_W), .PU_CYC(PU_CYC), .CV_CYC(CV_CYC)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_lvl    (s_lvl[B_ST]),
        .st_rise   (s_rise[B_ST]),
        .st_fall   (s_fall[B_ST]),
        .sample_in (sample_in),
        .phase     (phase),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .pend_ign  (pend_ignored),
        .port_en   (port_en)
    );

    adc_seq_shift #(.RES_W(RES_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .rd_lvl    (s_lvl[B_RD]),
        .rd_rise   (s_rise[B_RD]),
        .rd_fall   (s_fall[B_RD]),
        .port_en   (port_en),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    assign powered = (phase != PH_OFF);
    assign ready   = (phase == PH_TRACK);
    assign busy    = (phase == PH_CONV);
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic dout,
    input logic dout_en,
    input logic powered,
    input logic ready,
    input logic busy,
    input logic pend_ignored
);
    assert_phase_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ready, busy}));

    assert_off_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !powered |-> (!ready && !busy));

    assert_quiet_dout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> !dout);

    assert_conv_from_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ready));

    assert_down_after_conv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(powered) |-> $past(busy));

    assert_flag_clear_on_conv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !pend_ignored);
endmodule

bind adc_seq_top adc_seq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dout         (dout),
    .dout_en      (dout_en),
    .powered      (powered),
    .ready        (ready),
    .busy         (busy),
    .pend_ignored (pend_ignored)
);

// File: tb/adc_seq_top_bench.sv
`timescale 1ns/1ps
module adc_seq_top_bench;
    localparam int RES_W  = 10;
    localparam int PU_CYC = 188;
    localparam int CV_CYC = 288;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start = 1'b0;
    logic rd_active = 1'b0;
    logic sclk = 1'b0;
    logic [RES_W-1:0] sample_in = '0;
    logic dout, dout_en, powered, ready, busy, pend_ignored;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_seq_top #(.RES_W(RES_W), .PU_CYC(PU_CYC), .CV_CYC(CV_CYC)) u_adc_seq_top (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .rd_active(rd_active),
        .sclk(sclk), .sample_in(sample_in), .dout(dout), .dout_en(dout_en),
        .powered(powered), .ready(ready), .busy(busy), .pend_ignored(pend_ignored)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic read_word(output logic [RES_W-1:0] w);
        w = '0;
        rd_active = 1'b1;
        cyc(5);
        for (int i = 0; i < RES_W; i++) begin
            w = {w[RES_W-2:0], dout};
            sclk = 1'b1; cyc(4);
            sclk = 1'b0; cyc(5);
        end
        rd_active = 1'b0;
        cyc(6);
    endtask

    task automatic t_reset;
        cyc(3);
        chk("R1 powered", powered, 0);
        chk("R1 ready", ready, 0);
        chk("R1 busy", busy, 0);
        chk("R1 dout_en", dout_en, 0);
        chk("R1 dout", dout, 0);
        chk("R1 pend_ignored", pend_ignored, 0);
    endtask

    task automatic t_powerup_ignored;
        conv_start = 1'b1;
        cyc(6);
        chk("R2 powered during power-up", powered, 1);
        chk("R2 not ready early", ready, 0);
        cyc(14);
        conv_start = 1'b0;
        cyc(6);
        chk("R6 flag set", pend_ignored, 1);
        chk("R6 no conversion", busy, 0);
        cyc(PU_CYC - 32);
        chk("R2 ready not before PU_CYC", ready, 0);
        cyc(10);
        chk("R2 ready after PU_CYC", ready, 1);
        chk("R6 still no conversion", busy, 0);
    endtask

    task automatic t_fast_mode;
        logic [RES_W-1:0] w;
        conv_start = 1'b1;
        cyc(6);
        sample_in = 10'h3C1;
        conv_start = 1'b0;
        cyc(6);
        chk("R3 busy", busy, 1);
        chk("R6 flag cleared", pend_ignored, 0);
        sample_in = 10'h000;
        rd_active = 1'b1;
        cyc(5);
        chk("R7 port disabled dout_en", dout_en, 0);
        chk("R7 port disabled dout", dout, 0);
        rd_active = 1'b0;
        cyc(5);
        conv_start = 1'b1;
        cyc(CV_CYC - 30);
        chk("R3 still busy", busy, 1);
        cyc(20);
        chk("R4 ready again", ready, 1);
        chk("R4 powered", powered, 1);
        read_word(w);
        chk("R8 msb-first word", w, 10'h3C1);
    endtask

    task automatic t_low_power;
        logic [RES_W-1:0] w;
        sample_in = 10'h2A5;
        conv_start = 1'b0;
        cyc(6);
        sample_in = 10'h000;
        cyc(CV_CYC + 6);
        chk("R5 powered down", powered, 0);
        chk("R5 not ready", ready, 0);
        conv_start = 1'b1;
        cyc(5);
        chk("R2 re-power", powered, 1);
        read_word(w);
        chk("R5 result kept across power-down", w, 10'h2A5);
        cyc(PU_CYC);
        chk("R2 ready after re-power", ready, 1);
    endtask

    task automatic t_overlap;
        logic [RES_W-1:0] w;
        sample_in = 10'h0F0;
        conv_start = 1'b0;
        cyc(6);
        sample_in = 10'h000;
        conv_start = 1'b1;
        cyc(CV_CYC - 60);
        w = '0;
        rd_active = 1'b1;
        cyc(5);
        for (int i = 0; i < RES_W; i++) begin
            w = {w[RES_W-2:0], dout};
            if (i == 3) begin
                cyc(90);
                chk("R10 conversion ended during read", ready, 1);
            end
            sclk = 1'b1; cyc(4);
            sclk = 1'b0; cyc(5);
        end
        rd_active = 1'b0;
        cyc(6);
        chk("R9 overlapping read gives previous", w, 10'h2A5);
        read_word(w);
        chk("R10 deferred result loaded after read", w, 10'h0F0);
    endtask

    initial begin
        cyc(4);
        rst_n = 1'b1;
        t_reset();
        t_powerup_ignored();
        t_fast_mode();
        t_low_power();
        t_overlap();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int n = 0; n < 20000; n++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule